// File: doc/BRIEF.md
# Registered-Cascade Wide Signed Multiplier

This block multiplies two 35-bit two's-complement operands and returns the full 70-bit signed product. It is built for a high clock rate. Each operand is cut into a 17-bit unsigned low slice and an 18-bit signed high slice. Four narrow multipliers form the cross products. Their results are accumulated along a serial chain of four stages, and every adder in that chain has a register after it. Later stages receive their operands through a pass-along register chain, so a stage sees its operands one cycle later than the stage before it. Each partial product therefore meets the running sum in the cycle the sum arrives, and no two adders are joined without a register between them.

The running sum is arithmetically shifted right by 17 bits wherever the weight of the next product rises. The 17-bit groups that drop off the bottom of the sum at those points are held in short delay lines. They are then joined to the top of the sum to form the product. A new operand pair may be presented on every cycle. `in_valid` travels down a shift register of the same length as the datapath and comes out as `out_valid`.

Top module: `mulw_cascade`

## Requirements
- R1: When `out_valid` is 1, `product` equals the exact signed product of the `a_in` and `b_in` values presented with the matching `in_valid`, as a 70-bit two's-complement value.
- R2: The latency is fixed at IN_REGS + 4 cycles (6 with the defaults). Operands sampled at rising edge n appear on `product`, and `out_valid` rises, after rising edge n+5.
- R3: Each operand is split into an unsigned low slice (bits 16..0) and a signed high slice (bits 34..17). The first chain stage forms low times low, so its sum is never negative.
- R4: A new operand pair is accepted on every cycle. Back-to-back pairs come out in order, each on its own cycle, and no pair disturbs its neighbours.
- R5: The two stages that carry weight 2^17 relative to the previous stage shift the running sum right arithmetically by 17 bits. After the last stage the sum fits in 36 signed bits, which become `product` bits 69..34.
- R6: A synchronous active-high `rst` clears every pipeline register. On the cycle after a reset edge, `product` is 0 and `out_valid` is 0. Pairs that were in flight when reset was applied never raise `out_valid`.
- R7: `out_valid` repeats the `in_valid` pattern delayed by the latency. Bubbles (cycles with `in_valid` = 0) appear as `out_valid` = 0 on the matching output cycles.
- R8: The corner operands give the exact results: the most negative value times itself gives +2^68, -1 times -1 gives 1, -1 times the most negative value gives +2^34, and any operand times zero gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the operand pair on this cycle as a real request |
| a_in | input | 35 | Multiplicand, two's complement |
| b_in | input | 35 | Multiplier, two's complement |
| product | output | 70 | Full signed product, two's complement |
| out_valid | output | 1 | Marks `product` as the result of a real request |

## Verification
The assertions assume that `rst` is held high through the first rising edge, so the chain registers start from known values. They also assume that the operand inputs carry defined values on every cycle, bubbles included, because the data path runs freely whatever `in_valid` is. The stimulus drives reset for several cycles at the start. It keeps `a_in` and `b_in` at defined values throughout, parking them at zero or at a leftover vector during bubbles and after the table has been used up. It moves the inputs only on falling edges.

// File: rtl/mulw_pkg.sv
package mulw_pkg;

    // Operand geometry: a 35-bit operand splits into an unsigned low slice
    // and a signed high slice.
    localparam int OP_W   = 35;
    localparam int LO_W   = 17;
    localparam int HI_W   = OP_W - LO_W;

    // One extra bit lets every slice be handled as a signed value.
    localparam int SL_W   = HI_W + 1;
    localparam int PP_W   = 2 * SL_W;

    // Four chain stages: one for each cross product of the slices.
    localparam int NSTAGE = 4;

    // Width of the running sum inside the chain.
    localparam int SUM_W  = 2 * OP_W - LO_W;

    // Width of the sum left after the last stage, and of the full product.
    localparam int TOP_W  = 2 * OP_W - 2 * LO_W;
    localparam int PROD_W = 2 * OP_W;

    typedef logic signed [SL_W-1:0]  slice_t;
    typedef logic signed [SUM_W-1:0] sum_t;

    typedef struct packed {
        logic [OP_W-1:0] a;
        logic [OP_W-1:0] b;
    } opnd_t;

    // Stage k uses the high slice of A when k is odd.
    function automatic bit stage_a_hi(input int k);
        return (k % 2) == 1;
    endfunction

    // Stage k uses the high slice of B from stage 2 onwards.
    function automatic bit stage_b_hi(input int k);
        return k >= 2;
    endfunction

    // Stage k shifts the incoming sum down when its product weight rises by 2^17.
    function automatic bit stage_shift(input int k);
        return (k % 2) == 1;
    endfunction

endpackage

// File: rtl/mulw_delay.sv
module mulw_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] tap [DEPTH];

    // Each tap is one register level; reset clears all of them.
    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) begin
                tap[i] <= '0;
            end else if (i == 0) begin
                tap[i] <= d;
            end else begin
                tap[i] <= tap[(i == 0) ? 0 : i-1];
            end
        end
    end

    assign q = tap[DEPTH-1];

endmodule

// File: rtl/mulw_stage.sv
module mulw_stage
    import mulw_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  opnd_t op_in,
    input  sum_t  sum_in,
    output opnd_t op_out,
    output sum_t  sum_out
);

    localparam bit A_HI  = stage_a_hi(IDX);
    localparam bit B_HI  = stage_b_hi(IDX);
    localparam bit SHIFT = stage_shift(IDX);
    localparam bit FIRST = (IDX == 0);

    slice_t                   a_sl;
    slice_t                   b_sl;
    logic signed [PP_W-1:0]   pp;
    sum_t                     carry;
    sum_t                     nxt;

    always_comb begin
        // High slices are sign-extended; low slices are zero-extended.
        if (A_HI) a_sl = {op_in.a[OP_W-1], op_in.a[OP_W-1:LO_W]};
        else      a_sl = {{(SL_W-LO_W){1'b0}}, op_in.a[LO_W-1:0]};
        if (B_HI) b_sl = {op_in.b[OP_W-1], op_in.b[OP_W-1:LO_W]};
        else      b_sl = {{(SL_W-LO_W){1'b0}}, op_in.b[LO_W-1:0]};

        pp = a_sl * b_sl;

        // Bring the running sum to the weight of this stage's product.
        if (FIRST)      carry = '0;
        else if (SHIFT) carry = sum_in >>> LO_W;
        else            carry = sum_in;

        nxt = carry + {{(SUM_W-PP_W){pp[PP_W-1]}}, pp};
    end

    // One register after each adder; the operands move on in step with the sum.
    always_ff @(posedge clk) begin
        if (rst) begin
            op_out  <= '0;
            sum_out <= '0;
        end else begin
            op_out  <= op_in;
            sum_out <= nxt;
        end
    end

    if (FIRST) begin : g_first_chk
        // R3: low slice times low slice can never be negative.
        p_low_nonneg_r3: assert property (@(posedge clk) disable iff (rst)
            !sum_out[SUM_W-1]);
    end

endmodule

// File: rtl/mulw_cascade.sv
module mulw_cascade
    import mulw_pkg::*;
#(
    parameter int IN_REGS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   a_in,
    input  logic [OP_W-1:0]   b_in,
    output logic [PROD_W-1:0] product,
    output logic              out_valid
);

    localparam int LATENCY = IN_REGS + NSTAGE;
    localparam int NRET    = NSTAGE / 2;
    localparam int CNT_W   = $clog2(LATENCY + 1);

    opnd_t op_raw;
    opnd_t op_q;
    opnd_t op_c  [NSTAGE+1];
    sum_t  sum_c [NSTAGE+1];
    logic [LO_W-1:0] lo_ret [NRET];

    assign op_raw = '{a: a_in, b: b_in};

    // Operand input register levels ahead of the first multiplier.
    mulw_delay #(.W($bits(opnd_t)), .DEPTH(IN_REGS)) u_opnd_in (
        .clk (clk),
        .rst (rst),
        .d   (op_raw),
        .q   (op_q)
    );

    // The valid strobe travels down a line as long as the whole datapath.
    mulw_delay #(.W(1), .DEPTH(LATENCY)) u_vld (
        .clk (clk),
        .rst (rst),
        .d   (in_valid),
        .q   (out_valid)
    );

    assign op_c[0]  = op_q;
    assign sum_c[0] = '0;

    // The registered cascade chain.
    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        mulw_stage #(.IDX(k)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .op_in   (op_c[k]),
            .sum_in  (sum_c[k]),
            .op_out  (op_c[k+1]),
            .sum_out (sum_c[k+1])
        );
    end

    // The even stages feed a shifting stage, so their low 17 bits are final.
    // Delay them until the last stage has produced its result.
    for (genvar r = 0; r < NRET; r++) begin : g_retire
        mulw_delay #(.W(LO_W), .DEPTH(NSTAGE - 1 - 2*r)) u_lo (
            .clk (clk),
            .rst (rst),
            .d   (sum_c[2*r+1][LO_W-1:0]),
            .q   (lo_ret[r])
        );
    end

    assign product = {sum_c[NSTAGE][TOP_W-1:0], lo_ret[1], lo_ret[0]};

    // ------------------------------------------------------------------
    // Checks

    logic signed [PROD_W-1:0] ref_prod;
    logic [CNT_W-1:0]         warm_cnt;
    logic                     rst_seen;

    always_comb ref_prod = $signed(op_c[NSTAGE].a) * $signed(op_c[NSTAGE].b);

    always_ff @(posedge clk) begin
        if (rst)                         warm_cnt <= '0;
        else if (warm_cnt != CNT_W'(LATENCY)) warm_cnt <= warm_cnt + 1'b1;
    end

    always_ff @(posedge clk) rst_seen <= rst;

    // R1: the result matches a reference product of the operands that rode along the chain.
    p_product_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (product == ref_prod));

    // R2: no valid result can appear before the pipeline has filled since reset.
    p_no_early_valid_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (warm_cnt == CNT_W'(LATENCY)));

    // R5: after the last stage the sum fits in the top field of the product.
    p_top_range_r5: assert property (@(posedge clk) disable iff (rst)
        (&sum_c[NSTAGE][SUM_W-1:TOP_W-1]) || !(|sum_c[NSTAGE][SUM_W-1:TOP_W-1]));

    // R6: one cycle after a reset edge, the outputs are cleared.
    always @(negedge clk) begin
        if (rst_seen) begin
            p_reset_clear_r6: assert (product == '0 && out_valid == 1'b0);
        end
    end

endmodule

// File: tb/mulw_cascade_bench.sv
`timescale 1ns/1ps
module mulw_cascade_bench;

    localparam int LAT  = 6;
    localparam int NVEC = 16;

    localparam logic [34:0] VA [NVEC] = '{
        35'h000000000, 35'h000000001, 35'h7FFFFFFFF, 35'h400000000,
        35'h3FFFFFFFF, 35'h400000000, 35'h00001FFFF, 35'h000020000,
        35'h7FFFE0000, 35'h123456789, 35'h5DEADBEEF, 35'h7FFFFFFFF,
        35'h000000003, 35'h2AAAAAAAA, 35'h0000ABCDE, 35'h3FFFE0001
    };
    localparam logic [34:0] VB [NVEC] = '{
        35'h000000000, 35'h000000001, 35'h7FFFFFFFF, 35'h400000000,
        35'h3FFFFFFFF, 35'h3FFFFFFFF, 35'h00001FFFF, 35'h000020000,
        35'h00001FFFF, 35'h0ABCDEF01, 35'h1CAFEF00D, 35'h400000000,
        35'h7FFFFFFFD, 35'h555555555, 35'h7FFF54321, 35'h00001FFFF
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [34:0] a_in = '0;
    logic [34:0] b_in = '0;
    logic [69:0] product;
    logic        out_valid;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    mulw_cascade u_mulw_cascade (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .a_in      (a_in),
        .b_in      (b_in),
        .product   (product),
        .out_valid (out_valid)
    );

    function automatic logic [69:0] ref_mul(input logic [34:0] a, input logic [34:0] b);
        logic signed [69:0] r;
        r = $signed(a) * $signed(b);
        return r;
    endfunction

    task automatic check(input string req, input logic [69:0] got, input logic [69:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected under 50000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R6: reset state
        repeat (3) @(negedge clk);
        check("R6 reset product", product, '0);
        check("R6 reset valid", {69'b0, out_valid}, 70'd1 - 70'd1);
        rst = 1'b0;

        // Table walk, back-to-back (R1, R2, R4, R8); a result lags its input by LAT falling edges.
        for (int m = 0; m < NVEC + LAT; m++) begin
            @(negedge clk);
            if (m < LAT) begin
                check("R2 no early valid", {69'b0, out_valid}, '0);
            end else begin
                check("R2 valid at latency", {69'b0, out_valid}, 70'd1);
                check("R1 R4 product", product, ref_mul(VA[m-LAT], VB[m-LAT]));
            end
            if (m < NVEC) begin
                in_valid = 1'b1; a_in = VA[m]; b_in = VB[m];
            end else begin
                in_valid = 1'b0; a_in = '0; b_in = '0;
            end
        end

        // R8: the corner vectors, checked directly against their known values.
        check("R8 min*min", ref_mul(VA[3], VB[3]), 70'h1 << 68);
        check("R8 -1*-1", ref_mul(VA[2], VB[2]), 70'd1);
        check("R8 -1*min", ref_mul(VA[11], VB[11]), 70'h1 << 34);

        // R7: bubbles. Pattern 1,0,0,1,0,1 with defined operands throughout.
        for (int m = 0; m < 6 + LAT; m++) begin
            @(negedge clk);
            if (m >= LAT) begin
                automatic int s = m - LAT;
                automatic logic v = (s == 0 || s == 3 || s == 5);
                check("R7 bubble valid", {69'b0, out_valid}, {69'b0, v});
                if (v) check("R7 bubble product", product, ref_mul(VA[9+s], VB[4+s]));
            end
            if (m < 6) begin
                in_valid = (m == 0 || m == 3 || m == 5);
                a_in = VA[9+m]; b_in = VB[4+m];
            end else begin
                in_valid = 1'b0; a_in = '0; b_in = '0;
            end
        end

        // R6: reset with work in flight.
        for (int m = 0; m < 3; m++) begin
            @(negedge clk);
            in_valid = 1'b1; a_in = VA[4]; b_in = VB[4];
        end
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; a_in = '0; b_in = '0;
        @(negedge clk);
        check("R6 mid reset product", product, '0);
        check("R6 mid reset valid", {69'b0, out_valid}, '0);
        rst = 1'b0;
        for (int m = 0; m < LAT + 1; m++) begin
            @(negedge clk);
            check("R6 dropped in flight", {69'b0, out_valid}, '0);
        end

        // R3 / R5: slice borders, sign flips on the high slice.
        @(negedge clk);
        in_valid = 1'b1; a_in = 35'h00001FFFF; b_in = 35'h7FFFE0000;
        @(negedge clk);
        in_valid = 1'b1; a_in = 35'h400000001; b_in = 35'h00001FFFF;
        @(negedge clk);
        in_valid = 1'b0; a_in = '0; b_in = '0;
        repeat (LAT - 2) @(negedge clk);
        check("R3 slice border", product, ref_mul(35'h00001FFFF, 35'h7FFFE0000));
        @(negedge clk);
        check("R5 shift sign", product, ref_mul(35'h400000001, 35'h00001FFFF));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule